// File: doc/BRIEF.md
# Block copy and search sequencer

This block is a clocked engine that moves or scans a run of bytes in memory without further help from the rest of the chip. A one-cycle start pulse loads a source pointer, a destination pointer, a byte counter and an 8-bit key, and also selects the operation, the mode and the direction. A copy moves bytes from the source run to the destination run. A search compares each source byte with the key. Each step can advance the pointers upwards or downwards. In single mode the engine performs one step. In repeating mode it keeps stepping until the counter is exhausted or, for a search, until the key is found.

The engine reaches memory through one synchronous port. Read data comes back one cycle after the read request. The write of a copy step goes out in the cycle in which its read data arrives, so the steps of an overlapping copy happen in strict order. Each step lasts a fixed number of clock cycles. That number is longer for a step that will be followed by another and shorter for the final step. After the final step a one-cycle completion pulse appears. Two flags stay visible until the next run: one says that the counter is not yet zero, and the other says that the last compared byte matched the key.

Top module: `blk_xfer_engine`

## Requirements
- R1: After synchronous active-low reset, busy, done, cnt_nz, match, mem_we and mem_rd_en are all 0.
- R2: When the engine is idle, a start pulse loads src_init, dst_init, cnt_init and key, and busy is 1 in the following cycle. A start pulse that arrives while busy is 1 has no effect on the run in progress.
- R3: A copy step writes the byte read at the source pointer to the destination pointer and decrements the counter by one, modulo 2^CNT_W.
- R4: After each step, every pointer that moves goes up by one when dir_down=0 and down by one when dir_down=1. A copy step moves both the source and destination pointers. A search step moves only the source pointer.
- R5: After each step, cnt_nz is 1 exactly when the decremented counter is not zero.
- R6: With rep_mode=0 a run is exactly one step. With rep_mode=1 a copy keeps stepping until the counter reaches zero.
- R7: A search step sets match to 1 when the key equals the byte read and to 0 otherwise. A repeating search (rep_mode=1) stops after the first step that matches or the first step that leaves the counter at zero, whichever comes first. The match flag is 0 after a copy run.
- R8: A step that is followed by another step lasts REP_CYC cycles (default 21). The final step lasts LAST_CYC cycles (default 16). done is high for exactly one cycle, in the cycle after the final step, and busy is 0 in that cycle.
- R9: A start with cnt_init=0 makes a repeating copy perform 2^CNT_W steps, because the counter wraps on its first decrement.
- R10: mem_rd_en is raised with mem_addr equal to the source pointer, and the data is used one cycle later. mem_we is raised only in copy steps, and never while the engine is idle or searching, so a search leaves memory unchanged. op_search=1 selects a search and op_search=0 selects a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run (taken only when idle) |
| op_search | input | 1 | 1 selects search, 0 selects copy |
| rep_mode | input | 1 | 1 selects repeating mode, 0 selects single step |
| dir_down | input | 1 | 1 moves pointers downward, 0 upward |
| src_init | input | ADDR_W | Initial source pointer |
| dst_init | input | ADDR_W | Initial destination pointer |
| cnt_init | input | CNT_W | Initial byte counter (0 means 2^CNT_W) |
| key | input | DATA_W | Search key |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd_en | output | 1 | Memory read request; data returns next cycle |
| mem_rdata | input | DATA_W | Memory read data |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| cnt_nz | output | 1 | Counter not zero after the last step |
| match | output | 1 | The last search step found the key |
| src_ptr | output | ADDR_W | Current source pointer |
| dst_ptr | output | ADDR_W | Current destination pointer |
| count | output | CNT_W | Current byte counter |

## Verification
A counter or pointer that slips by one shows at the ports when the run ends. The final pointer or counter value is wrong, and done arrives 21 cycles early or late because the step count differs. A wrong last-step decision shows up as a completion pulse at the wrong cycle, or as a copy or search that goes past the point where it should stop. Both are visible within one step time of the error. A stray or misplaced write shows up in the memory contents, which are compared in full after every run. A misordered read/write pair in an overlapping copy makes the propagated byte pattern differ at the first overlapping step.

// File: rtl/blk_xfer_pkg.sv
// Shared types for the block copy and search sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package blk_xfer_pkg;

    // Sequencer phases within one run
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for start
        ST_READ = 2'd1,   // read request for the source byte
        ST_EXEC = 2'd2,   // read data valid: write or compare, step state
        ST_HOLD = 2'd3    // pad the step to its required length
    } seq_state_e;

endpackage

// File: rtl/blk_ptr_unit.sv
// Loadable up/down register used for the pointers and the byte counter.
// Assumes: load has priority over step; wraps modulo 2^W.
module blk_ptr_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         down,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] ONE = W'(1);

    // Hold, load or move the value by one place
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (step) begin
            q <= down ? (q - ONE) : (q + ONE);
        end
    end

endmodule

// File: rtl/blk_step_timer.sv
// Pads each step to its full length. It is armed in the execute cycle with
// the length of the current step (long for a step that is followed by
// another, short for the final one).
// Assumes: REP_CYC and LAST_CYC are both at least 3 (read + exec + >=1 hold).
module blk_step_timer #(
    parameter int REP_CYC  = 21,
    parameter int LAST_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic arm_last,
    output logic expired
);

    localparam int MAXC = (REP_CYC > LAST_CYC) ? REP_CYC : LAST_CYC;
    localparam int TW   = $clog2(MAXC);
    localparam logic [TW-1:0] REP_LD  = TW'(REP_CYC - 3);
    localparam logic [TW-1:0] LAST_LD = TW'(LAST_CYC - 3);

    logic [TW-1:0] remain;

    // Load the hold length on arm, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (arm) begin
            remain <= arm_last ? LAST_LD : REP_LD;
        end else if (remain != '0) begin
            remain <= remain - TW'(1);
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/blk_seq_ctrl.sv
// Phase sequencer: read, execute, hold; then either the next step or the end
// of the run with a one-cycle done pulse.
// Assumes: last_now is valid in ST_EXEC; timer_exp is valid in ST_HOLD.
module blk_seq_ctrl
    import blk_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       last_now,
    input  logic       timer_exp,
    output seq_state_e state,
    output logic       done
);

    seq_state_e state_nx;
    logic       last_q;
    logic       finish;

    assign finish = (state == ST_HOLD) && timer_exp && last_q;

    // Next-phase selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_READ;
            ST_READ: state_nx = ST_EXEC;
            ST_EXEC: state_nx = ST_HOLD;
            ST_HOLD: if (timer_exp) state_nx = last_q ? ST_IDLE : ST_READ;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Remember whether the step in flight is the final one
    always_ff @(posedge clk) begin
        if (!rst_n)                 last_q <= 1'b0;
        else if (state == ST_EXEC)  last_q <= last_now;
    end

    // One-cycle completion pulse after the final step
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finish;
    end

endmodule

// File: rtl/blk_xfer_engine.sv
// Block copy and search sequencer, top level.
// Holds the pointers, the counter, the key and the flags, drives the memory
// port, and decides in each execute cycle whether another step follows.
// Assumes: the memory returns read data one cycle after mem_rd_en and
// accepts a write in the cycle mem_we is high.
module blk_xfer_engine
    import blk_xfer_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 16,
    parameter int REP_CYC  = 21,
    parameter int LAST_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_search,
    input  logic              rep_mode,
    input  logic              dir_down,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    input  logic [CNT_W-1:0]  cnt_init,
    input  logic [DATA_W-1:0] key,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              cnt_nz,
    output logic              match,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic [CNT_W-1:0]  count
);

    seq_state_e        state;
    logic              take;
    logic              in_exec;
    logic              op_q, rep_q, down_q;
    logic [DATA_W-1:0] key_q;
    logic [CNT_W-1:0]  cnt_after;
    logic              hit;
    logic              last_now;
    logic              timer_exp;

    assign take      = start && (state == ST_IDLE);
    assign in_exec   = (state == ST_EXEC);
    assign cnt_after = count - CNT_W'(1);
    assign hit       = op_q && (key_q == mem_rdata);
    assign last_now  = !rep_q || (cnt_after == '0) || hit;

    // Capture the run configuration when a start is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= 1'b0;
            rep_q  <= 1'b0;
            down_q <= 1'b0;
            key_q  <= '0;
        end else if (take) begin
            op_q   <= op_search;
            rep_q  <= rep_mode;
            down_q <= dir_down;
            key_q  <= key;
        end
    end

    // Status flags: cleared on start, updated in every execute cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_nz <= 1'b0;
            match  <= 1'b0;
        end else if (take) begin
            cnt_nz <= 1'b0;
            match  <= 1'b0;
        end else if (in_exec) begin
            cnt_nz <= (cnt_after != '0);
            match  <= hit;
        end
    end

    blk_ptr_unit #(.W(ADDR_W)) u_src (
        .clk(clk), .rst_n(rst_n), .load(take), .load_val(src_init),
        .step(in_exec), .down(down_q), .q(src_ptr)
    );

    blk_ptr_unit #(.W(ADDR_W)) u_dst (
        .clk(clk), .rst_n(rst_n), .load(take), .load_val(dst_init),
        .step(in_exec && !op_q), .down(down_q), .q(dst_ptr)
    );

    blk_ptr_unit #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(take), .load_val(cnt_init),
        .step(in_exec), .down(1'b1), .q(count)
    );

    blk_step_timer #(.REP_CYC(REP_CYC), .LAST_CYC(LAST_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .arm(in_exec), .arm_last(last_now),
        .expired(timer_exp)
    );

    blk_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(take), .last_now(last_now),
        .timer_exp(timer_exp), .state(state), .done(done)
    );

    // Memory port: read the source in READ, write the destination in EXEC
    always_comb begin
        mem_rd_en = (state == ST_READ);
        mem_we    = in_exec && !op_q;
        mem_addr  = in_exec ? dst_ptr : src_ptr;
        mem_wdata = mem_rdata;
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/blk_xfer_checker.sv
// Temporal checks on the sequencer, attached to every instance by bind.
// Assumes: synchronous active-low reset.
module blk_xfer_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic              mem_rd_en,
    input logic [CNT_W-1:0]  count,
    input logic              cnt_nz,
    input logic [ADDR_W-1:0] dst_ptr
);

    // R8: completion is a single-cycle pulse, outside the busy window
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: no memory traffic while idle; a write always follows a read
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_rd_en));
    p_wr_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_rd_en));

    // R3: the counter moves only by a single decrement during a run
    p_cnt_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(count)) |-> (count == $past(count) - CNT_W'(1)));

    // R5: the nonzero flag tracks the counter after each step
    p_nz_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(count)) |-> (cnt_nz == (count != '0)));

    // R4: the destination pointer moves only alongside a copy write
    p_dst_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(dst_ptr)) |-> $past(mem_we));

endmodule

bind blk_xfer_engine blk_xfer_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_we(mem_we),
    .mem_rd_en(mem_rd_en), .count(count), .cnt_nz(cnt_nz), .dst_ptr(dst_ptr)
);

// File: tb/sim_blk_xfer_engine.sv
// Sweep bench: a small address and counter configuration run through all
// operation, mode and direction combinations. The expected results come from
// a step-by-step arithmetic model of the requirements.
module sim_blk_xfer_engine;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int RC = 21;
    localparam int LC = 16;
    localparam int MSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_search = 1'b0, rep_mode = 1'b0, dir_down = 1'b0;
    logic [AW-1:0] src_init = '0, dst_init = '0;
    logic [CW-1:0] cnt_init = '0;
    logic [DW-1:0] key = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_en, mem_we;
    logic [DW-1:0] mem_rdata, mem_wdata;
    logic          busy, done, cnt_nz, match;
    logic [AW-1:0] src_ptr, dst_ptr;
    logic [CW-1:0] count;

    logic [DW-1:0] mem     [MSZ];
    logic [DW-1:0] ref_mem [MSZ];

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    blk_xfer_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW),
                      .REP_CYC(RC), .LAST_CYC(LC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_search(op_search),
        .rep_mode(rep_mode), .dir_down(dir_down), .src_init(src_init),
        .dst_init(dst_init), .cnt_init(cnt_init), .key(key),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .cnt_nz(cnt_nz), .match(match), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
        .count(count)
    );

    // Synchronous memory with one-cycle read latency
    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One run: model it, drive it, compare ports and memory
    task automatic run_op(input bit op, input bit rep, input bit dn,
                          input int s0, input int d0, input int c0,
                          input int k, input bit inject);
        logic [AW-1:0] s = AW'(s0);
        logic [AW-1:0] d = AW'(d0);
        logic [CW-1:0] c = CW'(c0);
        logic [DW-1:0] b;
        bit   m = 0, last = 0;
        int   steps = 0, n, cyc, memerr;
        while (!last) begin
            b = ref_mem[s];
            if (!op) ref_mem[d] = b;
            m = op && (b == DW'(k));
            c = c - CW'(1);
            s = dn ? s - AW'(1) : s + AW'(1);
            if (!op) d = dn ? d - AW'(1) : d + AW'(1);
            steps++;
            last = !rep || (c == '0) || m;
        end
        cyc = (steps - 1) * RC + LC;

        @(negedge clk);
        op_search = op; rep_mode = rep; dir_down = dn;
        src_init = AW'(s0); dst_init = AW'(d0); cnt_init = CW'(c0); key = DW'(k);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
        check(count === CW'(c0), "R2 counter loaded", int'(count), c0);
        while (done !== 1'b1 && n < 8000) begin
            @(negedge clk);
            n++;
            if (inject && n == 5) begin
                src_init = ~AW'(s0); cnt_init = CW'(3); key = ~DW'(k);
                op_search = ~op; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        check(n == cyc + 1, "R8 run length", n, cyc + 1);
        check(busy === 1'b0, "R8 idle at done", int'(busy), 0);
        check(src_ptr === s, inject ? "R2 start ignored, src" : "R4 src pointer",
              int'(src_ptr), int'(s));
        check(dst_ptr === d, "R4 dst pointer", int'(dst_ptr), int'(d));
        check(count === c, (c0 == 0 && !op) ? "R9 wrapped count" : "R6 final count",
              int'(count), int'(c));
        check(cnt_nz === (c != '0), "R5 nonzero flag", int'(cnt_nz), int'(c != '0));
        check(match === m, "R7 match flag", int'(match), int'(m));
        memerr = 0;
        for (int i = 0; i < MSZ; i++) if (mem[i] !== ref_mem[i]) memerr++;
        check(memerr == 0, op ? "R10 search leaves memory" : "R3 copied bytes",
              memerr, 0);
        @(negedge clk);
        check(done === 1'b0, "R8 done one cycle", int'(done), 0);
    endtask

    // Watchdog: a hung run is a failure and still reaches the summary
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < MSZ; i++) begin
            mem[i]     = DW'(i * 7 + 3);
            ref_mem[i] = DW'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0,      "R1 busy",   int'(busy), 0);
        check(done === 1'b0,      "R1 done",   int'(done), 0);
        check(cnt_nz === 1'b0,    "R1 cnt_nz", int'(cnt_nz), 0);
        check(match === 1'b0,     "R1 match",  int'(match), 0);
        check(mem_we === 1'b0,    "R1 mem_we", int'(mem_we), 0);
        check(mem_rd_en === 1'b0, "R1 rd_en",  int'(mem_rd_en), 0);
        rst_n = 1'b1;

        // Sweep direction x mode x length for copy and search
        for (int dn = 0; dn < 2; dn++) begin
            for (int rp = 0; rp < 2; rp++) begin
                for (int li = 0; li < 4; li++) begin
                    int len  = (li == 3) ? 7 : li + 1;
                    int sb   = dn ? 140 : 40;
                    int db   = dn ? 230 : 120;
                    int off  = len / 2;
                    int kidx = dn ? sb - off : sb + off;
                    // R3/R6: copy
                    run_op(1'b0, rp[0], dn[0], sb, db, len, 0, 1'b0);
                    // R7: search for a byte inside the window
                    run_op(1'b1, rp[0], dn[0], sb, 0, len,
                           int'(ref_mem[kidx[AW-1:0]]), 1'b0);
                    // R7: search for a key absent from the window
                    run_op(1'b1, rp[0], dn[0], 60, 0, len,
                           int'(ref_mem[8'd59] + 8'd1), 1'b0);
                end
            end
        end
        // R3: overlapping forward copy propagates one byte
        run_op(1'b0, 1'b1, 1'b0, 10, 11, 5, 0, 1'b0);
        // R2: start pulse during a run
        run_op(1'b0, 1'b1, 1'b0, 70, 180, 6, 0, 1'b1);
        // R9: zero count wraps to 2^CW steps
        run_op(1'b0, 1'b1, 1'b0, 0, 0, 0, 0, 1'b0);
        run_op(1'b1, 1'b1, 1'b1, 200, 0, 0, 1000, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule